// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the command pins of a four-bank SDRAM and follows them one clock at a time. On each rising edge it reads chip select, the three strobe pins, the two bank-select pins, the A10 pin, a few low address bits and clock enable. It names the command those pins form and the bank the command is aimed at. It also says whether the command is allowed, given what each bank is doing at that moment and how many cycles have passed since the last related command.

For each bank it keeps a state: idle, row open, read burst, write burst, read or write burst that closes itself, or precharging. A set of minimum-gap counters, measured in clocks and set by module parameters, stands in for the real timing limits. A monitor or a bus-protocol checker places this block next to a memory controller to catch command streams that would break the device rules. It stores no data and drives nothing onto the memory bus.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When clock enable is low, or chip select is high with clock enable high, the edge reports command code 0 with the illegal flag low. With clock enable low, no bank state or counter moves.
- R2: With chip select low, the strobes {ras_n,cas_n,we_n} decode as follows. 111 is NOP (code 1). 101 is READ (2). 100 is WRITE (3). 011 is ACTIVATE (4). 010 is PRECHARGE (5). 001 is REFRESH (6). 000 is MODE SET (7). The pattern 110 is reported as NOP. Each report appears on `cmd_q` one cycle after the edge that sampled it.
- R3: The target bank is {ba0,ba1}, with ba0 as the most significant bit. It is reported on `bank_q`, and it is 0 when no command was decoded.
- R4: After reset, every command other than NOP and MODE SET is illegal until a legal MODE SET has been accepted. MODE SET is legal only when every bank is idle and no refresh is running. It latches the burst length from `mode_bits[1:0]` (0→1, 1→2, 2→4, 3→8 beats). It latches single-beat writes from `mode_bits[2]`.
- R5: ACTIVATE is legal only when the target bank is idle and at least T_RRD clocks have passed since the previous accepted ACTIVATE. An ACTIVATE to a bank that is already open is illegal. Per-bank state codes on `bank_st[3b+2:3b]` are: 0 idle, 1 open, 2 read, 3 write, 4 read with auto-close, 5 write with auto-close, 6 precharging.
- R6: READ and WRITE are legal only in two cases: the bank has been open for at least T_RCD clocks, or the bank is in a plain read or write burst. A10 high selects the auto-close variant (codes 4 and 5), and `ap_q` reports it.
- R7: A read burst holds its state for the latched burst length in cycles and then returns to open. A write does the same, except that it lasts a single cycle when single-beat writes are selected.
- R8: Once an auto-close burst ends, the bank precharges for T_RP cycles and then goes idle. While a bank is in an auto-close burst, READ, WRITE and single-bank PRECHARGE to it are illegal.
- R9: PRECHARGE with A10 low closes only the target bank. With A10 high it closes every open or bursting bank, and it is illegal while any bank is in an auto-close burst. PRECHARGE during a plain burst ends the burst at once. PRECHARGE to an idle bank is legal and changes nothing.
- R10: REFRESH is legal only when every bank is idle, or has finished its precharge time. After an accepted REFRESH, every command except NOP is illegal for T_RC cycles. The banks stay idle.
- R11: An illegal command changes no bank state.
- R12: A READ issued during a write burst to the same bank ends the write and starts a fresh read burst of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the tracker |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba0 | input | 1 | Bank select, high bit |
| ba1 | input | 1 | Bank select, low bit |
| a10 | input | 1 | Auto-close / close-all selector |
| mode_bits | input | 3 | Burst length and single-write bits sampled on MODE SET |
| cmd_q | output | 3 | Decoded command code |
| bank_q | output | 2 | Target bank of the command |
| ap_q | output | 1 | A10 was high on a READ, WRITE or PRECHARGE |
| illegal_q | output | 1 | Command broke a state or timing rule |
| bank_st | output | 12 | State code of each bank, 3 bits per bank |

## Verification
A command stream is used that opens banks 2, 1, 0 and 3 in turn. The order separates the high bank bit from the low one and makes the row-to-row and open-to-access gaps reach their limits. Repeated REFRESH attempts while a bank is still precharging tell "precharge issued" apart from "precharge finished". Burst lengths of 4 and 8, together with single-beat writes, show whether the burst counter is loaded from the latched mode or from a fixed value. Three directed sequences then probe the edges of the rules: a read that cuts into a write, a precharge during a read, and a suspended clock in the middle of an auto-close write.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RRD = 2,
  parameter int T_RC  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cke,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic        ba0,
  input  logic        ba1,
  input  logic        a10,
  input  logic [2:0]  mode_bits,
  output logic [2:0]  cmd_q,
  output logic [1:0]  bank_q,
  output logic        ap_q,
  output logic        illegal_q,
  output logic [11:0] bank_st
);
  localparam int M1   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int M2   = (T_RRD > T_RC) ? T_RRD : T_RC;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > 8) ? M3 : 8;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_OPEN = 3'd1, S_RD = 3'd2, S_WR = 3'd3,
    S_RDA = 3'd4, S_WRA = 3'd5, S_PRE = 3'd6
  } bst_t;

  localparam logic [2:0] C_NONE = 3'd0, C_NOP = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_ACT = 3'd4, C_PRE = 3'd5, C_REF = 3'd6, C_MRS = 3'd7;

  bst_t          st   [4];
  logic [CW-1:0] tmr  [4];
  logic [CW-1:0] rrd, refc;
  logic          cfg, single_wr;
  logic [1:0]    bl_code;
  logic [2:0]    cmd;
  logic [1:0]    tb;
  logic [3:0]    ready, ap_busy;
  logic          ok, fire;
  logic [3:0]    rd_last, wr_last;

  assign tb      = {ba0, ba1};
  assign rd_last = (4'd1 << bl_code) - 4'd1;
  assign wr_last = single_wr ? 4'd0 : rd_last;

  for (genvar g = 0; g < 4; g++) begin : g_bank
    assign ready[g]         = (st[g] == S_IDLE) || (st[g] == S_PRE && tmr[g] == '0);
    assign ap_busy[g]       = (st[g] == S_RDA) || (st[g] == S_WRA);
    assign bank_st[3*g +: 3] = st[g];
  end

  always_comb begin
    if (!cke || cs_n) cmd = C_NONE;
    else case ({ras_n, cas_n, we_n})
      3'b101:  cmd = C_RD;
      3'b100:  cmd = C_WR;
      3'b011:  cmd = C_ACT;
      3'b010:  cmd = C_PRE;
      3'b001:  cmd = C_REF;
      3'b000:  cmd = C_MRS;
      default: cmd = C_NOP;
    endcase
  end

  always_comb begin
    case (cmd)
      C_MRS: ok = (&ready) && refc == '0;
      C_ACT: ok = cfg && refc == '0 && ready[tb] && rrd == '0;
      C_RD, C_WR: ok = cfg && refc == '0 &&
                       ((st[tb] == S_OPEN && tmr[tb] == '0) || st[tb] == S_RD || st[tb] == S_WR);
      C_PRE: ok = cfg && refc == '0 && (a10 ? !(|ap_busy) : !ap_busy[tb]);
      C_REF: ok = cfg && refc == '0 && (&ready);
      default: ok = 1'b1;
    endcase
  end

  assign fire = ok && cmd != C_NONE && cmd != C_NOP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        st[b]  <= S_IDLE;
        tmr[b] <= '0;
      end
    end else if (cke) begin
      for (int b = 0; b < 4; b++) begin
        if (fire && cmd == C_ACT && tb == 2'(b)) begin
          st[b]  <= S_OPEN;
          tmr[b] <= CW'(T_RCD - 1);
        end else if (fire && (cmd == C_RD || cmd == C_WR) && tb == 2'(b)) begin
          if (cmd == C_RD) st[b] <= a10 ? S_RDA : S_RD;
          else             st[b] <= a10 ? S_WRA : S_WR;
          tmr[b] <= CW'(cmd == C_RD ? rd_last : wr_last);
        end else if (fire && cmd == C_PRE && (a10 || tb == 2'(b)) &&
                     (st[b] == S_OPEN || st[b] == S_RD || st[b] == S_WR)) begin
          st[b]  <= S_PRE;
          tmr[b] <= CW'(T_RP - 1);
        end else begin
          case (st[b])
            S_OPEN: if (tmr[b] != '0) tmr[b] <= tmr[b] - 1'b1;
            S_RD, S_WR:
              if (tmr[b] == '0) st[b] <= S_OPEN;
              else              tmr[b] <= tmr[b] - 1'b1;
            S_RDA, S_WRA:
              if (tmr[b] == '0) begin
                st[b]  <= S_PRE;
                tmr[b] <= CW'(T_RP - 1);
              end else tmr[b] <= tmr[b] - 1'b1;
            S_PRE:
              if (tmr[b] == '0) st[b] <= S_IDLE;
              else              tmr[b] <= tmr[b] - 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd       <= '0;
      refc      <= '0;
      cfg       <= 1'b0;
      bl_code   <= 2'd0;
      single_wr <= 1'b0;
    end else if (cke) begin
      if (fire && cmd == C_ACT)  rrd <= CW'(T_RRD - 1);
      else if (rrd != '0)        rrd <= rrd - 1'b1;
      if (fire && cmd == C_REF)  refc <= CW'(T_RC - 1);
      else if (refc != '0)       refc <= refc - 1'b1;
      if (fire && cmd == C_MRS) begin
        cfg       <= 1'b1;
        bl_code   <= mode_bits[1:0];
        single_wr <= mode_bits[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= C_NONE;
      bank_q    <= 2'd0;
      ap_q      <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      cmd_q     <= cmd;
      bank_q    <= (cmd != C_NONE) ? tb : 2'd0;
      ap_q      <= a10 && (cmd == C_RD || cmd == C_WR || cmd == C_PRE);
      illegal_q <= !ok;
    end
  end

  AST_QUIET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || cs_n) |=> (cmd_q == C_NONE && !illegal_q)); // R1
  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_st)); // R1
  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT && !illegal_q) |-> st[bank_q] == S_OPEN); // R5
  AST_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD && !illegal_q) |-> (st[bank_q] == S_RD || st[bank_q] == S_RDA)); // R6
  AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF && !illegal_q) |-> bank_st == 12'd0); // R10
endmodule

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic ba0 = 1'b0, ba1 = 1'b0, a10 = 1'b0;
  logic [2:0] mode_bits = 3'd0;
  logic [2:0] cmd_q;
  logic [1:0] bank_q;
  logic ap_q, illegal_q;
  logic [11:0] bank_st;
  int checks = 0, fails = 0;

  localparam logic [3:0] P_NOP = 4'b0111, P_RD = 4'b0101, P_WR = 4'b0100, P_ACT = 4'b0011,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000, P_DES = 4'b1101;

  sdram_cmd_tracker i_sdram_cmd_tracker (
    .clk, .rst_n, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba0, .ba1, .a10, .mode_bits,
    .cmd_q, .bank_q, .ap_q, .illegal_q, .bank_st
  );

  always #2.5 clk = ~clk;

  // pins[27:24] b0[23] b1[22] a10[21] mode[20:18] | cmd[17:15] bank[14:13] ill[12] st{b3,b2,b1,b0}[11:0]
  localparam int NV = 27;
  localparam logic [27:0] VEC [NV] = '{
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd0},
    {P_ACT, 1'b0,1'b1,1'b0,3'd0, 3'd4,2'd1,1'b1, 3'd0,3'd0,3'd0,3'd0},
    {P_MRS, 1'b0,1'b0,1'b0,3'd2, 3'd7,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd0},
    {P_ACT, 1'b1,1'b0,1'b0,3'd0, 3'd4,2'd2,1'b0, 3'd0,3'd1,3'd0,3'd0},
    {P_RD,  1'b1,1'b0,1'b0,3'd0, 3'd2,2'd2,1'b1, 3'd0,3'd1,3'd0,3'd0},
    {P_ACT, 1'b0,1'b1,1'b0,3'd0, 3'd4,2'd1,1'b0, 3'd0,3'd1,3'd1,3'd0},
    {P_RD,  1'b1,1'b0,1'b0,3'd0, 3'd2,2'd2,1'b0, 3'd0,3'd2,3'd1,3'd0},
    {P_ACT, 1'b0,1'b1,1'b0,3'd0, 3'd4,2'd1,1'b1, 3'd0,3'd2,3'd1,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd2,3'd1,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd2,3'd1,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd1,3'd1,3'd0},
    {P_WR,  1'b0,1'b1,1'b1,3'd0, 3'd3,2'd1,1'b0, 3'd0,3'd1,3'd5,3'd0},
    {P_RD,  1'b0,1'b1,1'b0,3'd0, 3'd2,2'd1,1'b1, 3'd0,3'd1,3'd5,3'd0},
    {P_PRE, 1'b0,1'b1,1'b0,3'd0, 3'd5,2'd1,1'b1, 3'd0,3'd1,3'd5,3'd0},
    {P_PRE, 1'b0,1'b0,1'b1,3'd0, 3'd5,2'd0,1'b1, 3'd0,3'd1,3'd5,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd1,3'd6,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd1,3'd6,3'd0},
    {P_REF, 1'b0,1'b0,1'b0,3'd0, 3'd6,2'd0,1'b1, 3'd0,3'd1,3'd0,3'd0},
    {P_PRE, 1'b0,1'b0,1'b1,3'd0, 3'd5,2'd0,1'b0, 3'd0,3'd6,3'd0,3'd0},
    {P_REF, 1'b0,1'b0,1'b0,3'd0, 3'd6,2'd0,1'b1, 3'd0,3'd6,3'd0,3'd0},
    {P_REF, 1'b0,1'b0,1'b0,3'd0, 3'd6,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd0},
    {P_ACT, 1'b0,1'b0,1'b0,3'd0, 3'd4,2'd0,1'b1, 3'd0,3'd0,3'd0,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd0},
    {P_NOP, 1'b0,1'b0,1'b0,3'd0, 3'd1,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd0},
    {P_ACT, 1'b0,1'b0,1'b0,3'd0, 3'd4,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd1},
    {P_DES, 1'b1,1'b1,1'b0,3'd0, 3'd0,2'd0,1'b0, 3'd0,3'd0,3'd0,3'd1},
    {P_ACT, 1'b1,1'b1,1'b0,3'd0, 3'd4,2'd3,1'b0, 3'd1,3'd0,3'd0,3'd1}
  };
  localparam string TAG [NV] = '{
    "R2", "R4", "R4", "R3", "R6", "R5", "R6", "R11", "R7", "R7", "R7", "R6", "R8", "R8",
    "R9", "R8", "R8", "R10", "R9", "R10", "R10", "R10", "R10", "R10", "R10", "R1", "R5"
  };

  task automatic go(input logic [3:0] p, input logic b0, input logic b1,
                    input logic a, input logic [2:0] md);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba0 = b0; ba1 = b1; a10 = a; mode_bits = md;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    ck("R1 reset", {17'd0, cmd_q, bank_q, illegal_q, bank_st}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      go(VEC[i][27:24], VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:18]);
      ck(TAG[i], {14'd0, cmd_q, bank_q, illegal_q, bank_st}, {14'd0, VEC[i][17:0]});
    end

    // fresh start: unconfigured again after reset
    rst_n = 1'b0;
    @(negedge clk);
    ck("R4 reset clears", {16'd0, illegal_q, 3'd0, bank_st}, 32'd0);
    rst_n = 1'b1;
    go(P_ACT, 0, 0, 0, 0);        ck("R4 act before mode", illegal_q, 1);
    go(P_MRS, 0, 0, 0, 3'b111);   ck("R4 mode set", illegal_q, 0);
    go(P_ACT, 0, 0, 0, 0);
    go(P_NOP, 0, 0, 0, 0);
    go(P_WR, 0, 0, 0, 0);         ck("R7 single write", bank_st, 12'd3);
    go(P_NOP, 0, 0, 0, 0);        ck("R7 single write ends", bank_st, 12'd1);
    go(P_RD, 0, 0, 0, 0);
    for (int k = 0; k < 7; k++) go(P_NOP, 0, 0, 0, 0);
    ck("R7 bl8 still reading", bank_st, 12'd2);
    go(P_NOP, 0, 0, 0, 0);        ck("R7 bl8 done", bank_st, 12'd1);
    go(P_MRS, 0, 0, 0, 3'b010);   ck("R4 mode while open", illegal_q, 1);
    go(P_RD, 0, 0, 0, 0);         ck("R9 read before close", bank_st, 12'd2);
    go(P_PRE, 0, 0, 0, 0);        ck("R9 close cuts read", {illegal_q, bank_st}, 13'd6);
    go(P_NOP, 0, 0, 0, 0);
    go(P_NOP, 0, 0, 0, 0);        ck("R8 close done", bank_st, 12'd0);

    go(P_MRS, 0, 0, 0, 3'b010);   ck("R4 remode bl4", illegal_q, 0);
    go(P_ACT, 0, 0, 0, 0);
    go(P_NOP, 0, 0, 0, 0);
    go(P_WR, 0, 0, 0, 0);         ck("R7 write bl4", bank_st, 12'd3);
    go(P_RD, 0, 0, 0, 0);         ck("R12 read cuts write", {illegal_q, bank_st}, 13'd2);
    for (int k = 0; k < 3; k++) go(P_NOP, 0, 0, 0, 0);
    ck("R12 read full length", bank_st, 12'd2);
    go(P_NOP, 0, 0, 0, 0);        ck("R12 read ends", bank_st, 12'd1);

    go(P_WR, 0, 0, 1, 0);         ck("R6 auto-close write", {ap_q, cmd_q, bank_st}, {1'b1, 3'd3, 12'd5});
    cke = 1'b0;
    go(P_ACT, 1, 1, 0, 0);        ck("R1 suspended edge", {cmd_q, illegal_q, bank_st}, {3'd0, 1'b0, 12'd5});
    go(P_PRE, 0, 0, 1, 0);        ck("R1 suspend holds", {cmd_q, illegal_q, bank_st}, {3'd0, 1'b0, 12'd5});
    cke = 1'b1;
    go(P_NOP, 0, 0, 0, 0);        ck("R2 nop decode", {cmd_q, bank_st}, {3'd1, 12'd5});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule